// File: doc/BRIEF.md
# Clock Synthesizer Power-Down Sequencer

This block sequences the low-power state of a clock synthesizer. A power-down request arrives as an active-low, asynchronous pin. Once the request has been synchronized, the sequencer first forces every clock output low and holds it there. Only after that does it drop the enables of the VCO and the crystal oscillator. While the sequence runs and for as long as the part stays powered down, the CPU-stop and bus-stop requests are masked, so they cannot reach the output stage.

When the request goes away, the oscillator enable returns first and the VCO enable one cycle later. The outputs stay forced low through a lock interval of `LOCK_CYCLES` reference cycles, and only then are they released. A new request during that interval sends the block back into the entry sequence. The analog oscillator and PLL are not modelled; they appear only as the two enable outputs.

Top module: `clk_pd_seq`

## Requirements
- R1: The power-down pin passes through a two-flop synchronizer. After `pd_n` falls, `force_low` first reads high following the third rising clock edge and reads low following the second.
- R2: Whenever `osc_en` or `vco_en` is low, `force_low` is high. In the cycle in which `force_low` first rises, both enables are still high.
- R3: Entry completes in fewer than three cycles of the synchronized request. Both enables read low one cycle after `force_low` rises.
- R4: After `pd_n` rises, `osc_en` reads high following the third rising edge while `vco_en` stays low. `vco_en` reads high one cycle later.
- R5: Once `vco_en` has returned, `force_low` stays high for exactly `LOCK_CYCLES` cycles and then falls. `force_low` falls only when a lock interval has completed.
- R6: From reset the block is in the running state: `force_low`=0, `osc_en`=1, `vco_en`=1, `stop_mask`=0, `cpu_halt`=0, `bus_halt`=0.
- R7: While the block is powered down or sequencing, `stop_mask` is 1, and `cpu_halt` and `bus_halt` are 0 whatever the levels of `cpu_stop_n` and `bus_stop_n`.
- R8: In the running state, a low level on `cpu_stop_n` or on `bus_stop_n` sets the matching halt output high two rising edges later. The two stop paths are independent of each other.
- R9: A request that arrives during the lock interval puts the block back in the force-low state with both enables high. One cycle later both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_n | input | 1 | Asynchronous power-down request, active low |
| cpu_stop_n | input | 1 | Asynchronous CPU/SDRAM clock stop request, active low |
| bus_stop_n | input | 1 | Asynchronous bus clock stop request, active low |
| force_low | output | 1 | Forces every clock output low |
| osc_en | output | 1 | Crystal oscillator enable |
| vco_en | output | 1 | VCO enable |
| stop_mask | output | 1 | High while the stop requests are don't-care |
| cpu_halt | output | 1 | Effective CPU/SDRAM stop |
| bus_halt | output | 1 | Effective bus stop |

## Verification
The assertions check, on every cycle, that the enables are never low while the outputs are released, that the VCO never runs without the oscillator, that the halts stay masked during power-down, that the force-low state leads to shutdown, that an abort during lock returns to force-low, and that a release follows a completed lock interval. Only the bench scenarios can show the exact cycle counts measured from the asynchronous pins: the synchronizer depth on entry and exit, the length of the lock interval, and the two-edge latency of the stop paths in the running state.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [2:0] {
    ST_RUN       = 3'd0,
    ST_FORCE_LOW = 3'd1,
    ST_OSC_OFF   = 3'd2,
    ST_WAKE      = 3'd3,
    ST_LOCK_WAIT = 3'd4
  } pd_state_e;

  typedef struct packed {
    logic force_low;
    logic osc_en;
    logic vco_en;
    logic stop_mask;
  } pd_ctl_t;

  // Output controls belonging to each state
  function automatic pd_ctl_t ctl_of_state(input pd_state_e s);
    pd_ctl_t c;
    c.force_low = 1'b1;
    c.osc_en    = 1'b1;
    c.vco_en    = 1'b1;
    c.stop_mask = 1'b1;
    case (s)
      ST_RUN: begin
        c.force_low = 1'b0;
        c.stop_mask = 1'b0;
      end
      ST_OSC_OFF: begin
        c.osc_en = 1'b0;
        c.vco_en = 1'b0;
      end
      ST_WAKE: c.vco_en = 1'b0;
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= RST_VAL;
      else if (i == 0) stage_q[i] <= d_async;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];

endmodule

// File: rtl/pdseq_lock_timer.sv
module pdseq_lock_timer #(
  parameter int LOCK_CYCLES = 28636,
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic done
);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic at_limit(input logic [CNT_W-1:0] c);
    return c == CNT_W'(LOCK_CYCLES - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (!at_limit(cnt_q)) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done = active && at_limit(cnt_q);

endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_req,
  input  logic      lock_done,
  output pd_state_e state,
  output logic      ev_enter,
  output logic      ev_abort
);

  pd_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RUN:       if (pd_req) nxt = ST_FORCE_LOW;
      ST_FORCE_LOW: nxt = ST_OSC_OFF;
      ST_OSC_OFF:   if (!pd_req) nxt = ST_WAKE;
      ST_WAKE:      nxt = pd_req ? ST_OSC_OFF : ST_LOCK_WAIT;
      ST_LOCK_WAIT: begin
        if (pd_req)         nxt = ST_FORCE_LOW;
        else if (lock_done) nxt = ST_RUN;
      end
      default:      nxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_RUN;
    else        state <= nxt;
  end

  assign ev_enter = (state == ST_RUN) && pd_req;
  assign ev_abort = (state == ST_LOCK_WAIT) && pd_req;

endmodule

// File: rtl/clk_pd_seq.sv
module clk_pd_seq
  import pdseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_CYCLES = 28636
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_n,
  input  logic cpu_stop_n,
  input  logic bus_stop_n,
  output logic force_low,
  output logic osc_en,
  output logic vco_en,
  output logic stop_mask,
  output logic cpu_halt,
  output logic bus_halt
);

  localparam int NUM_IN = 3;

  logic [NUM_IN-1:0] raw_n, sync_n;
  logic              pd_sync;
  logic              lock_done;
  logic              ev_enter, ev_abort;
  pd_state_e         state;
  pd_ctl_t           ctl;

  assign raw_n = {bus_stop_n, cpu_stop_n, pd_n};

  pdseq_sync #(
    .WIDTH(NUM_IN), .STAGES(SYNC_STAGES), .RST_VAL({NUM_IN{1'b1}})
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(raw_n), .q_sync(sync_n)
  );

  assign pd_sync = ~sync_n[0];

  pdseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_sync), .lock_done(lock_done),
    .state(state), .ev_enter(ev_enter), .ev_abort(ev_abort)
  );

  pdseq_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .active(state == ST_LOCK_WAIT), .done(lock_done)
  );

  assign ctl       = ctl_of_state(state);
  assign force_low = ctl.force_low;
  assign osc_en    = ctl.osc_en;
  assign vco_en    = ctl.vco_en;
  assign stop_mask = ctl.stop_mask;
  assign cpu_halt  = ~sync_n[1] & ~ctl.stop_mask;
  assign bus_halt  = ~sync_n[2] & ~ctl.stop_mask;

endmodule

// File: rtl/clk_pd_seq_chk.sv
module clk_pd_seq_chk
  import pdseq_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input pd_state_e state,
  input logic      pd_sync,
  input logic      lock_done,
  input logic      ev_enter,
  input logic      ev_abort,
  input logic      force_low,
  input logic      osc_en,
  input logic      vco_en,
  input logic      stop_mask,
  input logic      cpu_halt,
  input logic      bus_halt
);

  // R2: enables drop only while outputs are forced low
  a_r2_off_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en || !vco_en) |-> force_low);

  // R3: the force-low state is followed by shutdown
  a_r3_entry_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FORCE_LOW) |=> (!osc_en && !vco_en));

  // R4: the VCO never runs without the oscillator and restarts after it
  a_r4_osc_first: assert property (@(posedge clk) disable iff (!rst_n)
    vco_en |-> osc_en);
  a_r4_vco_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vco_en) |-> $past(osc_en));

  // R5: release only after a completed lock interval
  a_r5_release_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(force_low) |-> $past(lock_done));

  // R7: stop requests are masked while sequencing
  a_r7_stops_masked: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mask |-> (!cpu_halt && !bus_halt));

  // R9: a request during lock returns to force-low
  a_r9_abort_to_force: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (state == ST_FORCE_LOW && osc_en && vco_en));

  // R1: a synchronized request in run enters the sequence
  a_r1_enter: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enter |=> (force_low && pd_sync == $past(pd_sync)) || force_low);

endmodule

bind clk_pd_seq clk_pd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .pd_sync(pd_sync),
  .lock_done(lock_done), .ev_enter(ev_enter), .ev_abort(ev_abort),
  .force_low(force_low), .osc_en(osc_en), .vco_en(vco_en),
  .stop_mask(stop_mask), .cpu_halt(cpu_halt), .bus_halt(bus_halt)
);

// File: tb/test_clk_pd_seq.sv
module test_clk_pd_seq;

  localparam int LOCK = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1, cpu_stop_n = 1'b1, bus_stop_n = 1'b1;
  logic force_low, osc_en, vco_en, stop_mask, cpu_halt, bus_halt;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  clk_pd_seq #(.SYNC_STAGES(2), .LOCK_CYCLES(LOCK)) i_clk_pd_seq (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .cpu_stop_n(cpu_stop_n),
    .bus_stop_n(bus_stop_n), .force_low(force_low), .osc_en(osc_en),
    .vco_en(vco_en), .stop_mask(stop_mask), .cpu_halt(cpu_halt),
    .bus_halt(bus_halt)
  );

  task automatic check(input string req, input string what,
                       input logic [5:0] act, input logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {force_low, osc_en, vco_en, stop_mask, cpu_halt, bus_halt}
  function automatic logic [5:0] outs();
    return {force_low, osc_en, vco_en, stop_mask, cpu_halt, bus_halt};
  endfunction

  task automatic t_reset();
    tick(1);
    check("R6", "reset state", outs(), 6'b011000);
    rst_n = 1'b1;
    tick(2);
    check("R6", "after reset release", outs(), 6'b011000);
  endtask

  task automatic t_stops_run();
    cpu_stop_n = 1'b0;
    tick(1);
    check("R8", "cpu stop after one edge", outs(), 6'b011000);
    tick(1);
    check("R8", "cpu stop after two edges", outs(), 6'b011010);
    bus_stop_n = 1'b0; cpu_stop_n = 1'b1;
    tick(2);
    check("R8", "bus stop only", outs(), 6'b011001);
    bus_stop_n = 1'b1;
    tick(2);
    check("R8", "both released", outs(), 6'b011000);
  endtask

  task automatic t_entry();
    cpu_stop_n = 1'b0; bus_stop_n = 1'b0;
    tick(2);
    check("R8", "both stops in run", outs(), 6'b011011);
    pd_n = 1'b0;
    tick(2);
    check("R1", "still running after two edges", outs(), 6'b011011);
    tick(1);
    check("R1", "force low after third edge", outs(), 6'b111100);
    check("R2", "enables high as force rises", {4'b0, osc_en, vco_en}, 6'b000011);
    tick(1);
    check("R3", "enables off next cycle", outs(), 6'b100100);
    cpu_stop_n = 1'b1;
    tick(3);
    check("R7", "stops masked in power-down", outs(), 6'b100100);
    cpu_stop_n = 1'b0;
    tick(3);
    check("R7", "stops masked again", outs(), 6'b100100);
  endtask

  task automatic t_exit();
    int cnt;
    pd_n = 1'b1;
    tick(2);
    check("R4", "still off after two edges", outs(), 6'b100100);
    tick(1);
    check("R4", "oscillator first", outs(), 6'b110100);
    tick(1);
    check("R4", "vco one cycle later", outs(), 6'b111100);
    cnt = 0;
    for (int i = 0; i < 1000 && force_low; i++) begin
      cnt++;
      tick(1);
    end
    check("R5", "lock interval length", 6'(cnt), 6'(LOCK));
    check("R5", "released to run", outs(), 6'b011011);
  endtask

  task automatic t_abort();
    cpu_stop_n = 1'b1; bus_stop_n = 1'b1;
    pd_n = 1'b0;
    tick(6);
    check("R3", "powered down before abort test", outs(), 6'b100100);
    pd_n = 1'b1;
    tick(4);
    check("R9", "in lock wait", outs(), 6'b111100);
    tick(3);
    pd_n = 1'b0;
    tick(2);
    check("R9", "lock wait during sync", outs(), 6'b111100);
    tick(1);
    check("R9", "back to force low", outs(), 6'b111100);
    tick(1);
    check("R9", "enables off after abort", outs(), 6'b100100);
    pd_n = 1'b1;
    tick(4 + LOCK);
    check("R5", "run after full relock", outs(), 6'b011000);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_stops_run();
    t_entry();
    t_exit();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule